// File: doc/BRIEF.md
# Preload Hint Address Generator

This block works out the byte address for a cache preload hint and hands it to the memory system as a single request. A request carries a 32-bit base value and an offset. The offset is either a 12-bit unsigned immediate or a second register value passed through a shifter. A sign control picks whether the offset is added to the base or subtracted from it. The shifter has five modes: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate that pulls in a carry flag. All sums wrap modulo 2^32. The block never checks alignment, so any address may go out as a hint.

If a request asks for a shift amount outside the legal range of its mode, or names an unused mode code, no hint is issued. A one-cycle error pulse goes out instead. When the base comes from the program counter, the caller supplies the adjusted value.

The request side and the hint side each use a valid/ready handshake. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. Its result appears one clock later. `req_ready` is high whenever the hint register is empty or is being drained in that same cycle, so with `hint_ready` held high the block accepts one request per cycle. When the consumer holds `hint_ready` low, the pending hint stays in place and `req_ready` drops. `cfg_err` is a plain status pulse and has no handshake.

Top module: `pf_hint_agu`

## Requirements
- R1: With `off_is_reg`=0, the hint address is `base + imm` when `off_neg`=0 and `base - imm` when `off_neg`=1, where `imm` is the 12-bit unsigned value 0..4095; the sum wraps modulo 2^32.
- R2: An immediate of 0 in either sign passes `base` through unchanged as the hint address.
- R3: Shift mode code 0 (logical left) accepts amounts 0..31 and gives `rm << amt`.
- R4: Shift mode code 1 (logical right) accepts amounts 1..32 and fills with zeros; an amount of 32 gives 0.
- R5: Shift mode code 2 (arithmetic right) accepts amounts 1..32 and fills with copies of `rm[31]`; an amount of 32 gives 32 copies of the sign bit.
- R6: Shift mode code 3 (rotate right) accepts amounts 1..31 and gives `rm` rotated right by `amt`.
- R7: Shift mode code 4 (extended rotate) gives `{carry_in, rm[31:1]}` and ignores `amt`.
- R8: With `off_is_reg`=1, the shifted register value is added to `base` when `off_neg`=0 and subtracted from it when `off_neg`=1, modulo 2^32.
- R9: An accepted request whose amount is outside its mode's legal range, or whose mode code is 5..7, issues no hint and raises `cfg_err` for exactly the following cycle.
- R10: A legal accepted request raises `hint_valid` on the next clock. With `hint_ready` high, back-to-back requests give back-to-back hints in order.
- R11: While `hint_valid` is high and `hint_ready` is low, `hint_addr` stays unchanged and `req_ready` is low.
- R12: The address is never checked for alignment. A legal request with any low address bits issues its hint, and `cfg_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| base | input | 32 | Base address value |
| off_is_reg | input | 1 | 0: immediate offset, 1: shifted register offset |
| off_neg | input | 1 | 1: subtract offset, 0: add |
| imm | input | 12 | Immediate offset magnitude |
| rm | input | 32 | Register offset value |
| sh_mode | input | 3 | Shift mode code 0..4 |
| sh_amt | input | 6 | Shift amount |
| carry_in | input | 1 | Carry flag for extended rotate |
| hint_valid | output | 1 | Hint request present |
| hint_ready | input | 1 | Memory system takes the hint |
| hint_addr | output | 32 | Hint byte address |
| cfg_err | output | 1 | One-cycle illegal-shift pulse |

## Verification
Directed cases hit each edge of each mode's legal range. The legal edges are LSL 0 and 31, right shifts 1 and 32, and rotate 1 and 31. The matching illegal values just beyond them are also driven, which tells a wrong range bound apart from a wrong fill. For the right shifts, negative and positive `rm` values show zero fill apart from sign fill. The extended rotate is driven with both carry values and with a nonzero amount, which shows that the carry lands in the top bit and that `amt` has no effect. Random requests mix all eight mode codes, amounts up to 40, both signs and odd bases, so adder wraparound and borrow are both exercised. A stalled-consumer sequence and a back-to-back sequence tell the hold behaviour apart from in-order streaming.

// File: rtl/pf_hint_pkg.sv
package pf_hint_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } sh_mode_e;
endpackage

// File: rtl/pf_hint_shifter.sv
module pf_hint_shifter #(
  parameter int DW   = 32,
  parameter int SH_W = $clog2(DW) + 1
) (
  input  logic [DW-1:0]   rm,
  input  logic [2:0]      mode,
  input  logic [SH_W-1:0] amt,
  input  logic            carry_in,
  output logic [DW-1:0]   res,
  output logic            legal
);
  import pf_hint_pkg::*;

  localparam logic [SH_W-1:0] AMT_MAX  = SH_W'(DW);
  localparam logic [SH_W-1:0] AMT_TOP  = SH_W'(DW - 1);
  localparam logic [SH_W-1:0] AMT_ZERO = '0;

  logic [SH_W-1:0] inv_amt;
  assign inv_amt = AMT_MAX - amt;

  always_comb begin
    res   = rm;
    legal = 1'b0;
    case (sh_mode_e'(mode))
      SH_LSL: begin
        legal = (amt <= AMT_TOP);
        res   = rm << amt;
      end
      SH_LSR: begin
        legal = (amt != AMT_ZERO) && (amt <= AMT_MAX);
        res   = rm >> amt;
      end
      SH_ASR: begin
        legal = (amt != AMT_ZERO) && (amt <= AMT_MAX);
        res   = DW'($signed(rm) >>> amt);
      end
      SH_ROR: begin
        legal = (amt != AMT_ZERO) && (amt <= AMT_TOP);
        res   = (rm >> amt) | (rm << inv_amt);
      end
      SH_RRX: begin
        legal = 1'b1;
        res   = {carry_in, rm[DW-1:1]};
      end
      default: begin
        legal = 1'b0;
        res   = rm;
      end
    endcase
  end
endmodule

// File: rtl/pf_hint_addsub.sv
module pf_hint_addsub #(
  parameter int DW    = 32,
  parameter int IMM_W = 12
) (
  input  logic [DW-1:0]    base,
  input  logic             off_is_reg,
  input  logic             off_neg,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    reg_off,
  output logic [DW-1:0]    addr
);
  logic [DW-1:0] off;

  assign off  = off_is_reg ? reg_off : {{(DW-IMM_W){1'b0}}, imm};
  assign addr = off_neg ? (base - off) : (base + off);
endmodule

// File: rtl/pf_hint_agu.sv
module pf_hint_agu #(
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = $clog2(DW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DW-1:0]    base,
  input  logic             off_is_reg,
  input  logic             off_neg,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    rm,
  input  logic [2:0]       sh_mode,
  input  logic [SH_W-1:0]  sh_amt,
  input  logic             carry_in,
  output logic             hint_valid,
  input  logic             hint_ready,
  output logic [DW-1:0]    hint_addr,
  output logic             cfg_err
);
  logic [DW-1:0] sh_res;
  logic          sh_legal;
  logic          req_legal;
  logic [DW-1:0] next_addr;
  logic          take;

  pf_hint_shifter #(.DW(DW), .SH_W(SH_W)) u_shift (
    .rm       (rm),
    .mode     (sh_mode),
    .amt      (sh_amt),
    .carry_in (carry_in),
    .res      (sh_res),
    .legal    (sh_legal)
  );

  pf_hint_addsub #(.DW(DW), .IMM_W(IMM_W)) u_add (
    .base       (base),
    .off_is_reg (off_is_reg),
    .off_neg    (off_neg),
    .imm        (imm),
    .reg_off    (sh_res),
    .addr       (next_addr)
  );

  assign req_legal = !off_is_reg || sh_legal;
  assign req_ready = !hint_valid || hint_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_valid <= 1'b0;
      hint_addr  <= '0;
      cfg_err    <= 1'b0;
    end else begin
      cfg_err <= take && !req_legal;
      if (take && req_legal) begin
        hint_valid <= 1'b1;
        hint_addr  <= next_addr;
      end else if (hint_ready) begin
        hint_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pf_hint_chk.sv
module pf_hint_chk #(
  parameter int DW    = 32,
  parameter int IMM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [DW-1:0]    base,
  input logic             off_is_reg,
  input logic [IMM_W-1:0] imm,
  input logic             hint_valid,
  input logic             hint_ready,
  input logic [DW-1:0]    hint_addr,
  input logic             cfg_err
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !hint_ready) |=> (hint_valid && $stable(hint_addr))); // R11
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !hint_ready) |-> !req_ready); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (hint_valid != cfg_err)); // R10
  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(req_valid && req_ready)); // R9
  AST_HINT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hint_valid) |-> $past(req_valid && req_ready)); // R10
  AST_ZERO_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !off_is_reg && imm == '0)
      |=> (hint_valid && !cfg_err && hint_addr == $past(base))); // R2
endmodule

bind pf_hint_agu pf_hint_chk #(.DW(DW), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .base       (base),
  .off_is_reg (off_is_reg),
  .imm        (imm),
  .hint_valid (hint_valid),
  .hint_ready (hint_ready),
  .hint_addr  (hint_addr),
  .cfg_err    (cfg_err)
);

// File: tb/sim_pf_hint_agu.sv
module sim_pf_hint_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] base = '0;
  logic        off_is_reg = 1'b0;
  logic        off_neg = 1'b0;
  logic [11:0] imm = '0;
  logic [31:0] rm = '0;
  logic [2:0]  sh_mode = '0;
  logic [5:0]  sh_amt = '0;
  logic        carry_in = 1'b0;
  logic        hint_valid;
  logic        hint_ready = 1'b1;
  logic [31:0] hint_addr;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pf_hint_agu u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .base(base), .off_is_reg(off_is_reg), .off_neg(off_neg), .imm(imm),
    .rm(rm), .sh_mode(sh_mode), .sh_amt(sh_amt), .carry_in(carry_in),
    .hint_valid(hint_valid), .hint_ready(hint_ready), .hint_addr(hint_addr),
    .cfg_err(cfg_err)
  );

  function automatic logic [31:0] ref_shift(input logic [31:0] v, input int m,
      input int a, input logic c, output logic ok);
    logic [63:0] dbl;
    ok = 1'b0;
    ref_shift = v;
    case (m)
      0: begin ok = (a <= 31); ref_shift = v << a; end
      1: begin ok = (a >= 1 && a <= 32); ref_shift = (a >= 32) ? 32'd0 : v >> a; end
      2: begin
        ok = (a >= 1 && a <= 32);
        if (a >= 32) ref_shift = {32{v[31]}};
        else ref_shift = v[31] ? ~((~v) >> a) : (v >> a);
      end
      3: begin
        ok = (a >= 1 && a <= 31);
        dbl = {v, v} >> a;
        ref_shift = dbl[31:0];
      end
      4: begin ok = 1'b1; ref_shift = {c, v[31:1]}; end
      default: ok = 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic isr, input logic ng,
      input logic [11:0] im, input logic [31:0] r, input int m, input int a, input logic c);
    req_valid = 1'b1; base = b; off_is_reg = isr; off_neg = ng; imm = im;
    rm = r; sh_mode = 3'(m); sh_amt = 6'(a); carry_in = c;
  endtask

  // drive at negedge, check one full cycle later at the next negedge
  task automatic one(input string req, input logic [31:0] b, input logic isr,
      input logic ng, input logic [11:0] im, input logic [31:0] r, input int m,
      input int a, input logic c);
    logic ok;
    logic [31:0] off, exp;
    off = isr ? ref_shift(r, m, a, c, ok) : {20'd0, im};
    if (!isr) ok = 1'b1;
    exp = ng ? b - off : b + off;
    drive(b, isr, ng, im, r, m, a, c);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'd0, hint_valid}, {31'd0, ok});
    check({req, " err"}, {31'd0, cfg_err}, {31'd0, !ok});
    if (ok) check({req, " addr"}, hint_addr, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("reset hint_valid", {31'd0, hint_valid}, 32'd0);
    check("reset cfg_err", {31'd0, cfg_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle req_ready", {31'd0, req_ready}, 32'd1);

    one("R1 imm add", 32'h0000_1000, 0, 0, 12'd4095, '0, 0, 0, 0);
    one("R1 imm sub", 32'h0000_1000, 0, 1, 12'd2481, '0, 0, 0, 0);
    one("R1 wrap", 32'hFFFF_FFF0, 0, 0, 12'd280, '0, 0, 0, 0);
    one("R1 borrow", 32'h0000_0004, 0, 1, 12'd4095, '0, 0, 0, 0);
    one("R2 zero imm", 32'h1234_5677, 0, 0, 12'd0, '0, 0, 0, 0);
    one("R2 zero imm neg", 32'h89AB_CDEF, 0, 1, 12'd0, '0, 0, 0, 0);
    one("R3 lsl0", 32'h100, 1, 0, 0, 32'h55, 0, 0, 0);
    one("R3 lsl31", 32'h100, 1, 0, 0, 32'h3, 0, 31, 0);
    one("R9 lsl32", 32'h100, 1, 0, 0, 32'h3, 0, 32, 0);
    one("R4 lsr1", 32'h0, 1, 0, 0, 32'h8000_0002, 1, 1, 0);
    one("R4 lsr32", 32'h40, 1, 0, 0, 32'hFFFF_FFFF, 1, 32, 0);
    one("R9 lsr0", 32'h40, 1, 0, 0, 32'hFFFF_FFFF, 1, 0, 0);
    one("R5 asr1 neg", 32'h0, 1, 0, 0, 32'h8000_0004, 2, 1, 0);
    one("R5 asr32 neg", 32'h10, 1, 0, 0, 32'h8000_0000, 2, 32, 0);
    one("R5 asr32 pos", 32'h10, 1, 0, 0, 32'h7FFF_FFFF, 2, 32, 0);
    one("R9 asr33", 32'h10, 1, 0, 0, 32'h7FFF_FFFF, 2, 33, 0);
    one("R6 ror1", 32'h0, 1, 0, 0, 32'h0000_0003, 3, 1, 0);
    one("R6 ror31", 32'h0, 1, 0, 0, 32'h8000_0001, 3, 31, 0);
    one("R9 ror32", 32'h0, 1, 0, 0, 32'h8000_0001, 3, 32, 0);
    one("R9 ror0", 32'h0, 1, 0, 0, 32'h8000_0001, 3, 0, 0);
    one("R7 rrx c1", 32'h0, 1, 0, 0, 32'h0000_0003, 4, 0, 1);
    one("R7 rrx c0 amt ignored", 32'h0, 1, 0, 0, 32'h8000_0003, 4, 17, 0);
    one("R8 reg sub", 32'h1000, 1, 1, 0, 32'h4, 0, 2, 0);
    one("R8 reg add wrap", 32'hFFFF_FFFF, 1, 0, 0, 32'h2, 0, 0, 0);
    one("R9 mode5", 32'h1000, 1, 0, 0, 32'h4, 5, 2, 0);
    one("R9 mode7", 32'h1000, 1, 0, 0, 32'h4, 7, 2, 0);
    one("R12 odd addr", 32'h0000_0FFF, 0, 0, 12'd2, '0, 0, 0, 0);
    one("R12 odd reg", 32'h0000_0001, 1, 0, 0, 32'h1, 0, 0, 0);

    // R10 back-to-back
    drive(32'h100, 0, 0, 12'd1, '0, 0, 0, 0);
    @(negedge clk);
    check("R10 first valid", {31'd0, hint_valid}, 32'd1);
    check("R10 first addr", hint_addr, 32'h101);
    drive(32'h200, 0, 1, 12'd1, '0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second valid", {31'd0, hint_valid}, 32'd1);
    check("R10 second addr", hint_addr, 32'h1FF);
    @(negedge clk);
    check("R10 single pulse", {31'd0, hint_valid}, 32'd0);

    // R11 stall
    hint_ready = 1'b0;
    drive(32'h300, 0, 0, 12'd5, '0, 0, 0, 0);
    @(negedge clk);
    check("R11 stall valid", {31'd0, hint_valid}, 32'd1);
    check("R11 stall ready low", {31'd0, req_ready}, 32'd0);
    drive(32'h999, 0, 0, 12'd0, '0, 0, 0, 0);
    @(negedge clk);
    check("R11 held addr", hint_addr, 32'h305);
    check("R11 held valid", {31'd0, hint_valid}, 32'd1);
    req_valid = 1'b0;
    hint_ready = 1'b1;
    @(negedge clk);
    check("R11 drained", {31'd0, hint_valid}, 32'd0);

    for (int i = 0; i < 300; i++) begin
      one("R8 random", $urandom, 1'($urandom), 1'($urandom), 12'($urandom),
          $urandom, int'($urandom_range(7, 0)), int'($urandom_range(40, 0)),
          1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule